// File: doc/BRIEF.md
# Stretchable External Memory Cycle Sequencer

This block turns a single transfer request from a processor into the address, strobe and data timing of one access to external data memory. A small configuration register holds a 3-bit stretch setting. Higher settings lengthen every access so that slower shared memory or peripherals have time to respond. The stretch setting is taken once, at the moment a request is accepted, so a later change to the register affects only later accesses.

A read keeps the address valid and the read strobe high over the same window. It captures the memory data on the last strobe cycle and then pulses `done`. A write keeps the address and write data valid for one cycle more than a read at the same setting. Its write strobe follows its own width rule, with a floor of one cycle, and it always drops one cycle before the address window closes. This leaves hold time on the bus. The requester sees `busy` from acceptance through the `done` cycle. Any request made while `busy` is high is dropped.

Top module: `xmem_stretch_seq`

## Requirements
- R1: After reset, `busy`, `done`, `mem_addr_vld`, `mem_rd` and `mem_wr` are low, and the stretch setting is 1. An access made before any configuration write therefore behaves as stretch 1.
- R2: A read accepted with stretch s holds `mem_addr_vld` high for s+1 consecutive cycles. `mem_rd` is high in exactly those same cycles.
- R3: A write accepted with stretch s holds `mem_addr_vld` high for s+2 consecutive cycles.
- R4: A write strobe is high for max(1, s) consecutive cycles. So s=0 and s=1 both give one cycle. The strobe's last cycle is the second-to-last cycle of the address window.
- R5: A read loads `rd_data` with the value on `mem_rdata` in the last cycle of the read strobe. `rd_data` keeps that value after the access.
- R6: `done` is high for exactly one cycle, the cycle right after the address window. `busy` is high from the cycle after acceptance up to and including the `done` cycle.
- R7: A request is taken only when `busy` is low. A request raised while `busy` is high starts no access and is not remembered.
- R8: The stretch value used by an access is the one held at acceptance. A configuration write during an access changes only the next access.
- R9: `mem_rd` and `mem_wr` are never high in the same cycle. Throughout the address window, `mem_addr` equals the accepted address, and for writes `mem_wdata` equals the accepted write data.
- R10: R2 to R4 hold for every stretch setting from 0 to 7, loaded through `cfg_we`/`cfg_stretch`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock; every width is counted in its cycles |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Loads `cfg_stretch` into the stretch register |
| cfg_stretch | input | 3 | New stretch setting |
| req | input | 1 | Transfer request, taken when `busy` is low |
| req_wr | input | 1 | 1 for a write, 0 for a read |
| req_addr | input | 16 | Transfer address |
| req_wdata | input | 8 | Write data |
| busy | output | 1 | Access in progress, including the `done` cycle |
| done | output | 1 | One-cycle end-of-access pulse |
| mem_addr | output | 16 | Memory address, zero outside the window |
| mem_addr_vld | output | 1 | Address window |
| mem_rd | output | 1 | Read strobe, active high |
| mem_wr | output | 1 | Write strobe, active high |
| mem_wdata | output | 8 | Write data during a write window, otherwise zero |
| mem_rdata | input | 8 | Data returned by memory |
| rd_data | output | 8 | Captured read data |

## Verification
The sequencer's state is a phase, a cycle counter and three limits latched at acceptance. Any fault in them shows up at the ports within the access where it occurs. A wrong limit or counter makes the address window or a strobe one or more cycles off. It shifts `done`, and it changes which `mem_rdata` value lands in `rd_data`. All of these are visible in the first access after the fault, and at the latest in its `done` cycle. A bad reset value or a bad configuration path shows up in the first access that uses it. A sequencer that takes a request while busy shows up as an extra address window a few cycles after the current access.

// File: rtl/xmem_stretch_pkg.sv
package xmem_stretch_pkg;

   // phase of one external access
   typedef enum logic [1:0] {
      XS_IDLE = 2'd0,
      XS_XFER = 2'd1,
      XS_DONE = 2'd2
   } xs_phase_e;

   // counter width able to index a window of (2**sw - 1) + 2 cycles
   function automatic int unsigned xs_cnt_w(input int unsigned sw);
      return $clog2((2 ** sw) + 2);
   endfunction

endpackage

// File: rtl/xmem_stretch_cfg.sv
module xmem_stretch_cfg #(
   parameter int unsigned STRETCH_W     = 3,
   parameter int unsigned RESET_STRETCH = 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_en,
   input  logic [STRETCH_W-1:0] wr_val,
   output logic [STRETCH_W-1:0] stretch_q
);

   localparam logic [STRETCH_W-1:0] RST_VAL = STRETCH_W'(RESET_STRETCH);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         stretch_q <= RST_VAL;
      end else if (wr_en) begin
         stretch_q <= wr_val;
      end
   end

endmodule

// File: rtl/xmem_stretch_widths.sv
// Turns a stretch value and direction into window and strobe limits,
// expressed as counter indices inside the address window (first = 0).
module xmem_stretch_widths #(
   parameter int unsigned STRETCH_W = 3,
   parameter int unsigned CNT_W     = 4
) (
   input  logic [STRETCH_W-1:0] stretch,
   input  logic                 is_wr,
   output logic [CNT_W-1:0]     win_last,
   output logic [CNT_W-1:0]     stb_first,
   output logic [CNT_W-1:0]     stb_last
);

   logic [CNT_W-1:0] s_ext;
   logic             s_zero;

   assign s_ext  = CNT_W'(stretch);
   assign s_zero = (stretch == '0);

   always_comb begin
      if (is_wr) begin
         // window s+2; strobe max(1,s) ending one before window end (index s)
         win_last  = s_ext + CNT_W'(1);
         stb_first = s_zero ? '0 : CNT_W'(1);
         stb_last  = s_ext;
      end else begin
         // window s+1; strobe covers the whole window
         win_last  = s_ext;
         stb_first = '0;
         stb_last  = s_ext;
      end
   end

endmodule

// File: rtl/xmem_seq_fsm.sv
module xmem_seq_fsm
   import xmem_stretch_pkg::*;
#(
   parameter int unsigned ADDR_W = 16,
   parameter int unsigned DATA_W = 8,
   parameter int unsigned CNT_W  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req,
   input  logic              req_wr,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   input  logic [CNT_W-1:0]  lim_win_last,
   input  logic [CNT_W-1:0]  lim_stb_first,
   input  logic [CNT_W-1:0]  lim_stb_last,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic              busy,
   output logic              done,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              mem_addr_vld,
   output logic              mem_rd,
   output logic              mem_wr,
   output logic [DATA_W-1:0] mem_wdata,
   output logic [DATA_W-1:0] rd_data
);

   xs_phase_e         phase_q;
   logic [CNT_W-1:0]  cnt_q;
   logic              wr_q;
   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] wdata_q;
   logic [CNT_W-1:0]  win_last_q;
   logic [CNT_W-1:0]  stb_first_q;
   logic [CNT_W-1:0]  stb_last_q;

   logic in_win;
   logic in_stb;
   logic win_end;

   assign in_win  = (phase_q == XS_XFER);
   assign in_stb  = in_win && (cnt_q >= stb_first_q) && (cnt_q <= stb_last_q);
   assign win_end = in_win && (cnt_q == win_last_q);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase_q     <= XS_IDLE;
         cnt_q       <= '0;
         wr_q        <= 1'b0;
         addr_q      <= '0;
         wdata_q     <= '0;
         win_last_q  <= '0;
         stb_first_q <= '0;
         stb_last_q  <= '0;
         rd_data     <= '0;
      end else begin
         unique case (phase_q)
            XS_IDLE: begin
               if (req) begin
                  phase_q     <= XS_XFER;
                  cnt_q       <= '0;
                  wr_q        <= req_wr;
                  addr_q      <= req_addr;
                  wdata_q     <= req_wdata;
                  win_last_q  <= lim_win_last;
                  stb_first_q <= lim_stb_first;
                  stb_last_q  <= lim_stb_last;
               end
            end
            XS_XFER: begin
               if (win_end) begin
                  phase_q <= XS_DONE;
                  if (!wr_q) begin
                     rd_data <= mem_rdata;
                  end
               end else begin
                  cnt_q <= cnt_q + CNT_W'(1);
               end
            end
            XS_DONE: begin
               phase_q <= XS_IDLE;
            end
            default: begin
               phase_q <= XS_IDLE;
            end
         endcase
      end
   end

   assign busy         = (phase_q != XS_IDLE);
   assign done         = (phase_q == XS_DONE);
   assign mem_addr_vld = in_win;
   assign mem_addr     = in_win ? addr_q : '0;
   assign mem_wdata    = (in_win && wr_q) ? wdata_q : '0;
   assign mem_rd       = in_stb && !wr_q;
   assign mem_wr       = in_stb && wr_q;

endmodule

// File: rtl/xmem_stretch_seq.sv
module xmem_stretch_seq
   import xmem_stretch_pkg::*;
#(
   parameter int unsigned ADDR_W        = 16,
   parameter int unsigned DATA_W        = 8,
   parameter int unsigned STRETCH_W     = 3,
   parameter int unsigned RESET_STRETCH = 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 cfg_we,
   input  logic [STRETCH_W-1:0] cfg_stretch,
   input  logic                 req,
   input  logic                 req_wr,
   input  logic [ADDR_W-1:0]    req_addr,
   input  logic [DATA_W-1:0]    req_wdata,
   output logic                 busy,
   output logic                 done,
   output logic [ADDR_W-1:0]    mem_addr,
   output logic                 mem_addr_vld,
   output logic                 mem_rd,
   output logic                 mem_wr,
   output logic [DATA_W-1:0]    mem_wdata,
   input  logic [DATA_W-1:0]    mem_rdata,
   output logic [DATA_W-1:0]    rd_data
);

   localparam int unsigned CNT_W = xs_cnt_w(STRETCH_W);

   // elaboration-time parameter checks
   if (STRETCH_W < 1 || STRETCH_W > 6) begin : g_bad_stretch_w
      $error("xmem_stretch_seq: STRETCH_W must be 1..6");
   end
   if (RESET_STRETCH >= (2 ** STRETCH_W)) begin : g_bad_reset
      $error("xmem_stretch_seq: RESET_STRETCH does not fit STRETCH_W");
   end
   if (ADDR_W < 1 || DATA_W < 1) begin : g_bad_bus
      $error("xmem_stretch_seq: bus widths must be positive");
   end

   logic [STRETCH_W-1:0] stretch_q;
   logic [CNT_W-1:0]     lim_win_last;
   logic [CNT_W-1:0]     lim_stb_first;
   logic [CNT_W-1:0]     lim_stb_last;

   xmem_stretch_cfg #(
      .STRETCH_W     (STRETCH_W),
      .RESET_STRETCH (RESET_STRETCH)
   ) cfg_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (cfg_we),
      .wr_val    (cfg_stretch),
      .stretch_q (stretch_q)
   );

   xmem_stretch_widths #(
      .STRETCH_W (STRETCH_W),
      .CNT_W     (CNT_W)
   ) widths_i (
      .stretch   (stretch_q),
      .is_wr     (req_wr),
      .win_last  (lim_win_last),
      .stb_first (lim_stb_first),
      .stb_last  (lim_stb_last)
   );

   xmem_seq_fsm #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W),
      .CNT_W  (CNT_W)
   ) fsm_i (
      .clk           (clk),
      .rst_n         (rst_n),
      .req           (req),
      .req_wr        (req_wr),
      .req_addr      (req_addr),
      .req_wdata     (req_wdata),
      .lim_win_last  (lim_win_last),
      .lim_stb_first (lim_stb_first),
      .lim_stb_last  (lim_stb_last),
      .mem_rdata     (mem_rdata),
      .busy          (busy),
      .done          (done),
      .mem_addr      (mem_addr),
      .mem_addr_vld  (mem_addr_vld),
      .mem_rd        (mem_rd),
      .mem_wr        (mem_wr),
      .mem_wdata     (mem_wdata),
      .rd_data       (rd_data)
   );

endmodule

// File: rtl/xmem_stretch_seq_chk.sv
module xmem_stretch_seq_chk #(
   parameter int unsigned ADDR_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req,
   input logic              busy,
   input logic              done,
   input logic [ADDR_W-1:0] mem_addr,
   input logic              mem_addr_vld,
   input logic              mem_rd,
   input logic              mem_wr
);

   // R9
   strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_rd && mem_wr));

   // R2
   rd_in_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd |-> mem_addr_vld);

   // R4
   wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(mem_wr) |-> mem_addr_vld);

   // R6
   rd_then_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(mem_rd) |-> done);

   // R6
   done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R6
   window_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_addr_vld || done) |-> busy);

   // R7
   start_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_addr_vld) |-> $past(req && !busy));

   // R9
   addr_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_addr_vld && $past(mem_addr_vld)) |-> $stable(mem_addr));

endmodule

bind xmem_stretch_seq xmem_stretch_seq_chk #(.ADDR_W(ADDR_W)) chk_i (
   .clk          (clk),
   .rst_n        (rst_n),
   .req          (req),
   .busy         (busy),
   .done         (done),
   .mem_addr     (mem_addr),
   .mem_addr_vld (mem_addr_vld),
   .mem_rd       (mem_rd),
   .mem_wr       (mem_wr)
);

// File: tb/xmem_stretch_seq_tb_top.sv
`timescale 1ns/1ps
module xmem_stretch_seq_tb_top;

   localparam int unsigned AW = 16;
   localparam int unsigned DW = 8;
   localparam int unsigned SW = 3;

   // vector: {is_wr, stretch, addr, wdata}
   localparam logic [27:0] VEC [16] = '{
      {1'b0, 3'd0, 16'h1000, 8'h11},
      {1'b1, 3'd0, 16'h1001, 8'hA1},
      {1'b0, 3'd1, 16'h2002, 8'h22},
      {1'b1, 3'd1, 16'h2003, 8'hA2},
      {1'b0, 3'd2, 16'h3004, 8'h33},
      {1'b1, 3'd2, 16'h3005, 8'hA3},
      {1'b0, 3'd3, 16'h4006, 8'h44},
      {1'b1, 3'd3, 16'h4007, 8'hA4},
      {1'b0, 3'd4, 16'h5008, 8'h55},
      {1'b1, 3'd4, 16'h5009, 8'hA5},
      {1'b0, 3'd5, 16'h600A, 8'h66},
      {1'b1, 3'd5, 16'h600B, 8'hA6},
      {1'b0, 3'd6, 16'h700C, 8'h77},
      {1'b1, 3'd6, 16'h700D, 8'hA7},
      {1'b0, 3'd7, 16'h800E, 8'h88},
      {1'b1, 3'd7, 16'h800F, 8'hA8}
   };

   logic          clk = 1'b0;
   logic          rst_n;
   logic          cfg_we;
   logic [SW-1:0] cfg_stretch;
   logic          req;
   logic          req_wr;
   logic [AW-1:0] req_addr;
   logic [DW-1:0] req_wdata;
   logic          busy, done, mem_addr_vld, mem_rd, mem_wr;
   logic [AW-1:0] mem_addr;
   logic [DW-1:0] mem_wdata, mem_rdata, rd_data;

   int n_chk  = 0;
   int n_fail = 0;

   always #2.5 clk = ~clk;

   xmem_stretch_seq #(.ADDR_W(AW), .DATA_W(DW), .STRETCH_W(SW)) dut_i (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_stretch(cfg_stretch),
      .req(req), .req_wr(req_wr), .req_addr(req_addr), .req_wdata(req_wdata),
      .busy(busy), .done(done), .mem_addr(mem_addr), .mem_addr_vld(mem_addr_vld),
      .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_wdata(mem_wdata),
      .mem_rdata(mem_rdata), .rd_data(rd_data)
   );

   task automatic check(input bit ok, input string what, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
      end
   endtask

   task automatic summary();
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
   endtask

   task automatic set_stretch(input logic [SW-1:0] s);
      @(negedge clk);
      cfg_we      = 1'b1;
      cfg_stretch = s;
      @(negedge clk);
      cfg_we      = 1'b0;
   endtask

   // Issues one request and watches 24 cycles. exp_s is the stretch the
   // access must use. mid_cfg writes stretch 0 during the window (R8);
   // inject raises a second request while busy (R7).
   task automatic run_access(input bit wr, input logic [AW-1:0] addr,
                             input logic [DW-1:0] wdata, input int exp_s,
                             input bit mid_cfg, input bit inject);
      int n_av = 0, n_rd = 0, n_wr = 0, n_done = 0, n_busy = 0;
      int last_wr = -1, last_av = -1, done_i = -1, first_av = -1;
      int overlap = 0, bad_addr = 0, bad_wdata = 0;
      int exp_win, exp_stb;
      logic [DW-1:0] exp_rd;
      exp_win = wr ? exp_s + 2 : exp_s + 1;
      exp_stb = wr ? ((exp_s == 0) ? 1 : exp_s) : exp_s + 1;
      exp_rd  = addr[DW-1:0] ^ 8'h5A;
      @(negedge clk);
      req = 1'b1; req_wr = wr; req_addr = addr; req_wdata = wdata;
      @(negedge clk);
      req = 1'b0;
      for (int i = 0; i < 24; i++) begin
         if (mid_cfg && i == 0) begin cfg_we = 1'b1; cfg_stretch = '0; end
         if (mid_cfg && i == 1) cfg_we = 1'b0;
         if (inject && i == 2) begin req = 1'b1; req_addr = addr ^ 16'hFFFF; end
         if (inject && i == 3) req = 1'b0;
         mem_rdata = ~exp_rd;
         if (mem_addr_vld) begin
            n_av++;
            last_av = i;
            if (first_av < 0) first_av = i;
            if (mem_addr != addr) bad_addr++;
            if (wr && mem_wdata != wdata) bad_wdata++;
         end
         if (mem_rd) begin
            n_rd++;
            if (n_rd == exp_stb) mem_rdata = exp_rd;
         end
         if (mem_wr) begin n_wr++; last_wr = i; end
         if (mem_rd && mem_wr) overlap++;
         if (done) begin n_done++; done_i = i; end
         if (busy) n_busy++;
         @(negedge clk);
      end
      if (wr) begin
         check(n_av == exp_win && first_av == 0, "R3 write address window", n_av, exp_win);
         check(n_wr == exp_stb, "R4 write strobe width", n_wr, exp_stb);
         check(last_wr == exp_win - 2, "R4 write strobe end", last_wr, exp_win - 2);
         check(bad_wdata == 0, "R9 write data during window", bad_wdata, 0);
      end else begin
         check(n_av == exp_win && first_av == 0, "R2 read address window", n_av, exp_win);
         check(n_rd == exp_stb && n_wr == 0, "R2 read strobe width", n_rd, exp_stb);
         check(rd_data == exp_rd, "R5 captured read data", int'(rd_data), int'(exp_rd));
      end
      check(n_done == 1 && done_i == exp_win, "R6 done position", done_i, exp_win);
      check(n_busy == exp_win + 1, "R6 busy length", n_busy, exp_win + 1);
      check(overlap == 0 && bad_addr == 0, "R9 strobe overlap or address change",
            overlap + bad_addr, 0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      check(1'b0, "watchdog expired", 0, 1);
      summary();
      $finish;
   end

   initial begin
      rst_n = 1'b0; cfg_we = 1'b0; cfg_stretch = '0; req = 1'b0;
      req_wr = 1'b0; req_addr = '0; req_wdata = '0; mem_rdata = '0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 idle outputs after reset
      check(!busy && !done && !mem_addr_vld && !mem_rd && !mem_wr,
            "R1 reset outputs", int'({busy, done, mem_addr_vld, mem_rd, mem_wr}), 0);
      // R1 reset stretch is 1: read and write before any configuration
      run_access(1'b0, 16'h0ABC, 8'h00, 1, 1'b0, 1'b0);
      run_access(1'b1, 16'h0ABD, 8'h3C, 1, 1'b0, 1'b0);

      // R10 every stretch setting in both directions
      for (int v = 0; v < 16; v++) begin
         set_stretch(VEC[v][26:24]);
         run_access(VEC[v][27], VEC[v][23:8], VEC[v][7:0],
                    int'(VEC[v][26:24]), 1'b0, 1'b0);
      end

      // R8 configuration write during an access affects the next one only
      set_stretch(3'd7);
      run_access(1'b0, 16'hBEEF, 8'h00, 7, 1'b1, 1'b0);
      run_access(1'b0, 16'hBEF0, 8'h00, 0, 1'b0, 1'b0);

      // R7 request while busy is dropped (window count would grow otherwise)
      set_stretch(3'd4);
      run_access(1'b0, 16'hC0DE, 8'h00, 4, 1'b0, 1'b1);
      run_access(1'b1, 16'hC0DF, 8'h5E, 4, 1'b0, 1'b1);
      @(negedge clk);
      check(!busy && !mem_addr_vld, "R7 idle after ignored request",
            int'({busy, mem_addr_vld}), 0);

      summary();
      $finish;
   end

endmodule